// File: doc/BRIEF.md
# D-PHY Lane Group Power Sequencer

This block brings a D-PHY lane group into and out of operation on command. A start pulse releases the PHY reset, waits a fixed settling time, enables the PHY and hands the test interface to direct control. The sequencer then reads the PHY's internal state over the indirect test bus at a fixed interval. It stops when the state reports a quiet lane (idle or ultra-low-power) or when an overall time budget runs out. On success it drops the two force-receive-mode controls and reports ready. A timeout leaves a sticky error flag and the last state it read.

The first successful start after reset also captures a termination-calibration result. After a calibration settling wait, the sequencer reads a completion flag and, if the flag is set, reads the 4-bit calibration code and keeps it. Later starts reuse the stored code and skip these reads. A stop pulse disables the PHY, asserts its reset, returns the test interface to state-machine mode and issues a test-interface reset request. Frequency-range setup and the test bus itself sit outside this block. All delays are counted in reference-clock cycles from a cycles-per-microsecond parameter.

Top module: `dphy_pwr_seq`

## Requirements
- R1: After reset, phy_reset_n, phy_enable, tif_direct, force_rx, tbus_req, busy, ready, error and cal_valid are all 0.
- R2: A start pulse seen while idle raises phy_reset_n at the clock edge that samples it and sets force_rx to 2'b11. phy_enable and tif_direct rise exactly RST_WAIT_US*CYC_PER_US cycles later, and phy_enable is never high while phy_reset_n is low.
- R3: The PHY state is polled with read requests (tbus_op 0 = read, 1 = write, 2 = reset) to address 0x01E. The state is taken from read data bits [3:0]. At least POLL_US*CYC_PER_US cycles pass between an acknowledge and the next poll request. last_state shows the most recent polled value, and a request holds its address and operation until acknowledged.
- R4: A polled state of 7 (idle) or 8 (ultra-low-power) ends polling. force_rx is cleared to 0 no later than the edge that raises ready.
- R5: If no quiet state is seen within TIMEOUT_US*CYC_PER_US cycles of phy_enable rising, error is set and stays set, ready stays 0, busy drops, force_rx keeps 2'b11 and last_state keeps the last polled value. The error appears later than the budget and at most a few cycles plus one bus latency after it.
- R6: A stop pulse seen while idle lowers phy_enable, then phy_reset_n on the next edge, then tif_direct on the edge after that. A reset request (tbus_op 2) is raised from the same edge as the mode change. ready is cleared.
- R7: With no code stored, after success the sequencer waits at least CAL_WAIT_US*CYC_PER_US cycles and reads address 0x221. If bit 7 is set, it reads address 0x220, stores bits [5:2] in cal_code and sets cal_valid together with ready.
- R8: If bit 7 of address 0x221 is 0, no read of 0x220 is made and cal_valid stays 0.
- R9: While cal_valid is 1, a power-up issues no calibration reads and cal_code is unchanged.
- R10: Start and stop pulses are ignored while busy, no test-bus request is raised while idle, and an accepted start clears error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_up | input | 1 | Power-up command pulse |
| cmd_down | input | 1 | Power-down command pulse |
| phy_reset_n | output | 1 | PHY reset, active low |
| phy_enable | output | 1 | PHY shutdown release (1 = running) |
| tif_direct | output | 1 | Test interface access mode: 1 direct control, 0 state-machine |
| force_rx | output | 2 | Force-receive-mode controls |
| tbus_req | output | 1 | Test-bus request, held until acknowledged |
| tbus_op | output | 2 | Request kind: 0 read, 1 write, 2 reset |
| tbus_addr | output | 12 | Test register address |
| tbus_ack | input | 1 | Test-bus completion pulse |
| tbus_rdata | input | 8 | Read data, valid with tbus_ack |
| busy | output | 1 | Sequence in progress |
| ready | output | 1 | Power-up finished successfully |
| error | output | 1 | Sticky power-up timeout flag |
| last_state | output | 4 | Most recent polled PHY state |
| cal_valid | output | 1 | Calibration code captured |
| cal_code | output | 4 | Captured termination-calibration code |

## Verification
The power-up is driven with several polled-state histories. A walk through non-quiet states that ends at idle shows that polling repeats and honours its spacing. An immediate ultra-low-power answer shows that both quiet codes end the loop. A state that never becomes quiet shows that the timeout path is taken. A short walk after an error shows that a new start clears the flag. The calibration flag is presented set with no code stored, set with a code already stored, and clear after a fresh reset, which separates capture, reuse and skip. A stop pulse given in the middle of polling, checked against a scoreboard of expected test-bus transactions, shows that commands are ignored while busy.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_UP_DLY,
        S_POLL_RD,
        S_POLL_WAIT,
        S_FRC_CLR,
        S_CAL_DLY,
        S_CAL_FLAG,
        S_CAL_CODE,
        S_DN_RST,
        S_DN_MODE,
        S_DN_TRST
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_RESET = 2'd2
    } tbus_op_e;

    localparam logic [11:0] ADDR_PHY_STATE = 12'h01E;
    localparam logic [11:0] ADDR_CAL_FLAG  = 12'h221;
    localparam logic [11:0] ADDR_CAL_CODE  = 12'h220;

    localparam logic [3:0] PST_IDLE = 4'd7;
    localparam logic [3:0] PST_ULP  = 4'd8;

    typedef struct packed {
        seq_state_e  state;
        logic        phy_rst_n;
        logic        phy_en;
        logic        direct;
        logic [1:0]  frc;
        logic        ready;
        logic        err;
        logic [3:0]  last;
        logic        cal_valid;
        logic [3:0]  cal_code;
    } seq_regs_t;

endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         reached
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (en && (cnt_q != '1)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign reached = (cnt_q >= limit);

endmodule

// File: rtl/pwrseq_state_eval.sv
module pwrseq_state_eval
    import pwrseq_pkg::*;
(
    input  logic [7:0] rdata,
    output logic [3:0] phy_state,
    output logic       lane_quiet,
    output logic       cal_done,
    output logic [3:0] cal_field
);

    logic unused_bit6;

    assign unused_bit6 = rdata[6];
    assign phy_state   = rdata[3:0];
    assign lane_quiet  = (rdata[3:0] == PST_IDLE) || (rdata[3:0] == PST_ULP);
    assign cal_done    = rdata[7];
    assign cal_field   = rdata[5:2];

endmodule

// File: rtl/dphy_pwr_seq.sv
module dphy_pwr_seq
    import pwrseq_pkg::*;
#(
    parameter int CYC_PER_US  = 100,
    parameter int RST_WAIT_US = 10,
    parameter int POLL_US     = 100,
    parameter int TIMEOUT_US  = 5000000,
    parameter int CAL_WAIT_US = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_up,
    input  logic        cmd_down,
    output logic        phy_reset_n,
    output logic        phy_enable,
    output logic        tif_direct,
    output logic [1:0]  force_rx,
    output logic        tbus_req,
    output logic [1:0]  tbus_op,
    output logic [11:0] tbus_addr,
    input  logic        tbus_ack,
    input  logic [7:0]  tbus_rdata,
    output logic        busy,
    output logic        ready,
    output logic        error,
    output logic [3:0]  last_state,
    output logic        cal_valid,
    output logic [3:0]  cal_code
);

    localparam int RST_CYC  = CYC_PER_US * RST_WAIT_US;
    localparam int POLL_CYC = CYC_PER_US * POLL_US;
    localparam int CAL_CYC  = CYC_PER_US * CAL_WAIT_US;
    localparam int TO_CYC   = CYC_PER_US * TIMEOUT_US;
    localparam int STEP_MAX = (RST_CYC > POLL_CYC)
                              ? ((RST_CYC > CAL_CYC) ? RST_CYC : CAL_CYC)
                              : ((POLL_CYC > CAL_CYC) ? POLL_CYC : CAL_CYC);
    localparam int STEP_W   = $clog2(STEP_MAX + 1);
    localparam int TO_W     = $clog2(TO_CYC + 1);

    localparam logic [STEP_W-1:0] RST_LIM  = STEP_W'(RST_CYC - 1);
    localparam logic [STEP_W-1:0] POLL_LIM = STEP_W'(POLL_CYC - 1);
    localparam logic [STEP_W-1:0] CAL_LIM  = STEP_W'(CAL_CYC - 1);
    localparam logic [TO_W-1:0]   TO_LIM   = TO_W'(TO_CYC);

    seq_regs_t q, d;

    logic              step_clr, step_en, step_hit;
    logic              el_clr, el_en, el_hit;
    logic [STEP_W-1:0] step_limit;
    logic [3:0]        rd_state;
    logic              rd_quiet;
    logic              rd_cal_done;
    logic [3:0]        rd_cal_field;

    // Step timer: one shared counter for the settling, poll and calibration waits
    always_comb begin
        case (q.state)
            S_UP_DLY:    step_limit = RST_LIM;
            S_POLL_WAIT: step_limit = POLL_LIM;
            S_CAL_DLY:   step_limit = CAL_LIM;
            default:     step_limit = '1;
        endcase
    end

    pwrseq_timer #(.W(STEP_W)) u_step_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (step_clr),
        .en      (step_en),
        .limit   (step_limit),
        .reached (step_hit)
    );

    // Elapsed timer: measures the whole polling phase against the budget
    pwrseq_timer #(.W(TO_W)) u_elapsed_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (el_clr),
        .en      (el_en),
        .limit   (TO_LIM),
        .reached (el_hit)
    );

    pwrseq_state_eval u_eval (
        .rdata      (tbus_rdata),
        .phy_state  (rd_state),
        .lane_quiet (rd_quiet),
        .cal_done   (rd_cal_done),
        .cal_field  (rd_cal_field)
    );

    always_comb begin
        d        = q;
        step_clr = 1'b1;
        step_en  = 1'b0;
        el_clr   = 1'b1;
        el_en    = 1'b0;
        case (q.state)
            S_IDLE: begin
                if (cmd_up) begin
                    d.phy_rst_n = 1'b1;
                    d.phy_en    = 1'b0;
                    d.frc       = 2'b11;
                    d.ready     = 1'b0;
                    d.err       = 1'b0;
                    d.state     = S_UP_DLY;
                end else if (cmd_down) begin
                    d.phy_en = 1'b0;
                    d.ready  = 1'b0;
                    d.state  = S_DN_RST;
                end
            end
            S_UP_DLY: begin
                step_clr = 1'b0;
                step_en  = 1'b1;
                if (step_hit) begin
                    d.phy_en = 1'b1;
                    d.direct = 1'b1;
                    d.state  = S_POLL_RD;
                end
            end
            S_POLL_RD: begin
                el_clr = 1'b0;
                el_en  = 1'b1;
                if (tbus_ack) begin
                    d.last = rd_state;
                    if (rd_quiet) begin
                        d.state = S_FRC_CLR;
                    end else if (el_hit) begin
                        d.err   = 1'b1;
                        d.state = S_IDLE;
                    end else begin
                        d.state = S_POLL_WAIT;
                    end
                end
            end
            S_POLL_WAIT: begin
                el_clr   = 1'b0;
                el_en    = 1'b1;
                step_clr = 1'b0;
                step_en  = 1'b1;
                if (el_hit) begin
                    d.err   = 1'b1;
                    d.state = S_IDLE;
                end else if (step_hit) begin
                    d.state = S_POLL_RD;
                end
            end
            S_FRC_CLR: begin
                d.frc = 2'b00;
                if (q.cal_valid) begin
                    d.ready = 1'b1;
                    d.state = S_IDLE;
                end else begin
                    d.state = S_CAL_DLY;
                end
            end
            S_CAL_DLY: begin
                step_clr = 1'b0;
                step_en  = 1'b1;
                if (step_hit) d.state = S_CAL_FLAG;
            end
            S_CAL_FLAG: begin
                if (tbus_ack) begin
                    if (rd_cal_done) begin
                        d.state = S_CAL_CODE;
                    end else begin
                        d.ready = 1'b1;
                        d.state = S_IDLE;
                    end
                end
            end
            S_CAL_CODE: begin
                if (tbus_ack) begin
                    d.cal_code  = rd_cal_field;
                    d.cal_valid = 1'b1;
                    d.ready     = 1'b1;
                    d.state     = S_IDLE;
                end
            end
            S_DN_RST: begin
                d.phy_rst_n = 1'b0;
                d.state     = S_DN_MODE;
            end
            S_DN_MODE: begin
                d.direct = 1'b0;
                d.state  = S_DN_TRST;
            end
            S_DN_TRST: begin
                if (tbus_ack) d.state = S_IDLE;
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: S_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    // Test-bus request decoded from the registered state
    always_comb begin
        tbus_req  = 1'b0;
        tbus_op   = OP_READ;
        tbus_addr = '0;
        case (q.state)
            S_POLL_RD:  begin tbus_req = 1'b1; tbus_addr = ADDR_PHY_STATE; end
            S_CAL_FLAG: begin tbus_req = 1'b1; tbus_addr = ADDR_CAL_FLAG;  end
            S_CAL_CODE: begin tbus_req = 1'b1; tbus_addr = ADDR_CAL_CODE;  end
            S_DN_TRST:  begin tbus_req = 1'b1; tbus_op = OP_RESET;         end
            default: ;
        endcase
    end

    assign phy_reset_n = q.phy_rst_n;
    assign phy_enable  = q.phy_en;
    assign tif_direct  = q.direct;
    assign force_rx    = q.frc;
    assign busy        = (q.state != S_IDLE);
    assign ready       = q.ready;
    assign error       = q.err;
    assign last_state  = q.last;
    assign cal_valid   = q.cal_valid;
    assign cal_code    = q.cal_code;

    // R2: the PHY is only enabled while its reset is released
    assert_enable_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phy_enable |-> phy_reset_n);

    // R3: a pending request keeps its address and kind until acknowledged
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tbus_req && !tbus_ack) |=> (tbus_req && $stable(tbus_addr) && $stable(tbus_op)));

    // R4: ready never rises while force-receive controls are still set
    assert_ready_frc_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (force_rx == 2'b00));

    // R5: a timeout ends the sequence without ready and leaves a non-quiet state
    assert_timeout_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> (!busy && !ready && last_state != PST_IDLE && last_state != PST_ULP));

    // R6: reset is asserted only after the PHY has been disabled
    assert_down_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phy_reset_n) |-> !phy_enable);

    // R7: a captured code is published together with ready
    assert_cal_with_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_valid) |-> ready);

    // R10: no test-bus traffic while idle
    assert_idle_no_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tbus_req);

endmodule

// File: tb/dphy_pwr_seq_tb.sv
module dphy_pwr_seq_tb;

    localparam int CPU      = 1;
    localparam int RST_US   = 10;
    localparam int POLL_US  = 4;
    localparam int TO_US    = 60;
    localparam int CAL_US   = 5;
    localparam int RST_CYC  = CPU * RST_US;
    localparam int POLL_CYC = CPU * POLL_US;
    localparam int TO_CYC   = CPU * TO_US;
    localparam int CAL_CYC  = CPU * CAL_US;
    localparam int LAT      = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_up = 1'b0;
    logic        cmd_down = 1'b0;
    logic        phy_reset_n, phy_enable, tif_direct;
    logic [1:0]  force_rx;
    logic        tbus_req;
    logic [1:0]  tbus_op;
    logic [11:0] tbus_addr;
    logic        tbus_ack = 1'b0;
    logic [7:0]  tbus_rdata = 8'h00;
    logic        busy, ready, error, cal_valid;
    logic [3:0]  last_state, cal_code;

    dphy_pwr_seq #(
        .CYC_PER_US (CPU),
        .RST_WAIT_US(RST_US),
        .POLL_US    (POLL_US),
        .TIMEOUT_US (TO_US),
        .CAL_WAIT_US(CAL_US)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_up(cmd_up), .cmd_down(cmd_down),
        .phy_reset_n(phy_reset_n), .phy_enable(phy_enable), .tif_direct(tif_direct),
        .force_rx(force_rx), .tbus_req(tbus_req), .tbus_op(tbus_op),
        .tbus_addr(tbus_addr), .tbus_ack(tbus_ack), .tbus_rdata(tbus_rdata),
        .busy(busy), .ready(ready), .error(error), .last_state(last_state),
        .cal_valid(cal_valid), .cal_code(cal_code)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- scoreboard of test-bus transactions ----------------
    typedef struct {
        logic [1:0]  op;
        logic [11:0] addr;
        string       tag;
    } txn_t;

    txn_t exp_q[$];
    bit   loose_poll = 1'b0;
    bit   first_poll = 1'b0;

    task automatic expect_txn(input logic [1:0] op, input logic [11:0] addr, input string tag);
        txn_t t;
        t.op = op; t.addr = addr; t.tag = tag;
        exp_q.push_back(t);
    endtask

    // PHY model contents
    logic [3:0] st_seq[8];
    int         st_len = 1;
    int         poll_idx = 0;
    logic       cal_flag = 1'b0;
    logic [7:0] cal_word = 8'h00;

    bit          pending = 1'b0;
    int          lat_cnt = 0;
    logic [11:0] cur_addr = '0;
    int          last_ack_cyc = 0;
    int          trst_cyc = 0;

    always @(negedge clk) begin
        if (tbus_ack) begin
            tbus_ack     = 1'b0;
            pending      = 1'b0;
        end else if (pending) begin
            if (lat_cnt == 0) begin
                tbus_ack = 1'b1;
                last_ack_cyc = cyc;
                if (cur_addr == 12'h01E) begin
                    tbus_rdata = {4'h0, st_seq[poll_idx]};
                    if (poll_idx < st_len - 1) poll_idx++;
                end else if (cur_addr == 12'h221) begin
                    tbus_rdata = {cal_flag, 7'b0};
                end else if (cur_addr == 12'h220) begin
                    tbus_rdata = cal_word;
                end else begin
                    tbus_rdata = 8'h00;
                end
            end else begin
                lat_cnt--;
            end
        end
        if (rst_n && !pending && !tbus_ack && tbus_req) begin
            pending  = 1'b1;
            lat_cnt  = LAT;
            cur_addr = tbus_addr;
            if (tbus_op == 2'd2) trst_cyc = cyc;
            if (tbus_addr == 12'h01E && tbus_op == 2'd0) begin
                if (!first_poll)
                    chk((cyc - last_ack_cyc) >= POLL_CYC, "R3", "poll spacing",
                        cyc - last_ack_cyc, POLL_CYC);
                first_poll = 1'b0;
            end
            if (tbus_addr == 12'h221)
                chk((cyc - last_ack_cyc) >= CAL_CYC, "R7", "calibration wait",
                    cyc - last_ack_cyc, CAL_CYC);
            if (loose_poll && tbus_addr == 12'h01E) begin
                chk(tbus_op == 2'd0, "R3", "poll op", int'(tbus_op), 0);
            end else if (exp_q.size() == 0) begin
                chk(1'b0, "R10", "unexpected request addr", int'(tbus_addr), -1);
            end else begin
                txn_t t;
                t = exp_q.pop_front();
                chk(tbus_op == t.op && tbus_addr == t.addr, t.tag, "request op/addr",
                    int'({tbus_op, tbus_addr}), int'({t.op, t.addr}));
            end
        end
    end

    // ---------------- edge tracker on the PHY control pins ----------------
    logic p_rst = 1'b0, p_en = 1'b0, p_dir = 1'b0, p_err = 1'b0;
    int rst_rise = 0, rst_fall = 0, en_rise = 0, en_fall = 0, dir_fall = 0, err_rise = 0;

    always @(negedge clk) begin
        if (phy_reset_n && !p_rst) rst_rise = cyc;
        if (!phy_reset_n && p_rst) rst_fall = cyc;
        if (phy_enable && !p_en)   en_rise  = cyc;
        if (!phy_enable && p_en)   en_fall  = cyc;
        if (!tif_direct && p_dir)  dir_fall = cyc;
        if (error && !p_err)       err_rise = cyc;
        p_rst = phy_reset_n; p_en = phy_enable; p_dir = tif_direct; p_err = error;
    end

    // ---------------- driver tasks ----------------
    int up_cyc = 0;

    task automatic start_up();
        poll_idx   = 0;
        first_poll = 1'b1;
        @(negedge clk);
        cmd_up = 1'b1;
        up_cyc = cyc;
        @(negedge clk);
        cmd_up = 1'b0;
    endtask

    task automatic stop_down();
        @(negedge clk);
        cmd_down = 1'b1;
        @(negedge clk);
        cmd_down = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            if (!busy && !pending) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic power_down_checked();
        expect_txn(2'd2, 12'h000, "R6");
        stop_down();
        wait_idle();
        chk(rst_fall == en_fall + 1, "R6", "reset after disable", rst_fall - en_fall, 1);
        chk(dir_fall == rst_fall + 1, "R6", "mode after reset", dir_fall - rst_fall, 1);
        chk(trst_cyc == dir_fall, "R6", "reset request with mode", trst_cyc - dir_fall, 0);
        chk(!ready && !phy_enable && !phy_reset_n && !tif_direct, "R6", "pins low, ready clear",
            int'({ready, phy_enable, phy_reset_n, tif_direct}), 0);
        chk(exp_q.size() == 0, "R6", "scoreboard drained", exp_q.size(), 0);
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk({phy_reset_n, phy_enable, tif_direct, force_rx, tbus_req, busy, ready, error, cal_valid} == '0,
            "R1", "reset outputs",
            int'({phy_reset_n, phy_enable, tif_direct, force_rx, tbus_req, busy, ready, error, cal_valid}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Scenario A: walk 0,1,4,7 with calibration capture; stop pulse while busy
        st_seq[0] = 4'd0; st_seq[1] = 4'd1; st_seq[2] = 4'd4; st_seq[3] = 4'd7; st_len = 4;
        cal_flag = 1'b1; cal_word = 8'b1011_0110;
        for (int i = 0; i < 4; i++) expect_txn(2'd0, 12'h01E, "R3");
        expect_txn(2'd0, 12'h221, "R7");
        expect_txn(2'd0, 12'h220, "R7");
        start_up();
        for (int i = 0; i < 100; i++) begin
            if (phy_enable) break;
            @(negedge clk);
        end
        chk(force_rx == 2'b11 && tif_direct, "R2", "force and direct at enable",
            int'({force_rx, tif_direct}), 7);
        repeat (3) @(negedge clk);
        cmd_down = 1'b1;                      // R10: ignored while busy
        @(negedge clk);
        cmd_down = 1'b0;
        @(negedge clk);
        chk(phy_enable && busy, "R10", "stop ignored while busy", int'({phy_enable, busy}), 3);
        wait_idle();
        chk(rst_rise == up_cyc + 1, "R2", "reset release edge", rst_rise - up_cyc, 1);
        chk(en_rise - rst_rise == RST_CYC, "R2", "reset to enable delay", en_rise - rst_rise, RST_CYC);
        chk(ready && !error, "R4", "ready after idle state", int'({ready, error}), 2);
        chk(force_rx == 2'b00, "R4", "force cleared", int'(force_rx), 0);
        chk(last_state == 4'd7, "R3", "last polled state", int'(last_state), 7);
        chk(cal_valid && cal_code == 4'd13, "R7", "captured code", int'({cal_valid, cal_code}), 29);
        chk(exp_q.size() == 0, "R7", "scoreboard drained", exp_q.size(), 0);

        power_down_checked();

        // Scenario B: immediate ULP, code already stored
        st_seq[0] = 4'd8; st_len = 1;
        cal_flag = 1'b1; cal_word = 8'h00;
        expect_txn(2'd0, 12'h01E, "R4");
        start_up();
        wait_idle();
        chk(ready && last_state == 4'd8, "R4", "ULP accepted", int'({ready, last_state}), 24);
        chk(cal_valid && cal_code == 4'd13, "R9", "code kept", int'({cal_valid, cal_code}), 29);
        chk(exp_q.size() == 0, "R9", "no calibration reads", exp_q.size(), 0);

        power_down_checked();

        // Scenario C: state stuck at 3 -> timeout
        st_seq[0] = 4'd3; st_len = 1;
        loose_poll = 1'b1;
        start_up();
        wait_idle();
        loose_poll = 1'b0;
        chk(error && !ready && !busy, "R5", "timeout flags", int'({error, ready, busy}), 4);
        chk(last_state == 4'd3, "R5", "state kept", int'(last_state), 3);
        chk(force_rx == 2'b11, "R5", "force kept", int'(force_rx), 3);
        chk((err_rise - en_rise) > TO_CYC && (err_rise - en_rise) <= TO_CYC + LAT + 4,
            "R5", "timeout window", err_rise - en_rise, TO_CYC + 1);
        repeat (5) @(negedge clk);
        chk(error, "R5", "error sticky", int'(error), 1);

        power_down_checked();

        // Scenario D: new start clears the error
        st_seq[0] = 4'd2; st_seq[1] = 4'd7; st_len = 2;
        expect_txn(2'd0, 12'h01E, "R10");
        expect_txn(2'd0, 12'h01E, "R10");
        start_up();
        wait_idle();
        chk(!error && ready, "R10", "start clears error", int'({error, ready}), 1);

        power_down_checked();

        // Scenario E: fresh reset, calibration flag clear
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!cal_valid && !ready, "R1", "reset clears code and ready", int'({cal_valid, ready}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        st_seq[0] = 4'd7; st_len = 1;
        cal_flag = 1'b0; cal_word = 8'hFF;
        expect_txn(2'd0, 12'h01E, "R8");
        expect_txn(2'd0, 12'h221, "R8");
        start_up();
        wait_idle();
        chk(ready && !cal_valid, "R8", "no capture when flag clear", int'({ready, cal_valid}), 2);
        chk(exp_q.size() == 0, "R8", "no code read", exp_q.size(), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule